// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for a slow always-on clock domain. Software programs it over a simple word-addressed write/read port that runs on the system clock. Every register write must carry a per-register key or an exact code word. Writes without it are dropped with no side effect, so stray or corrupted stores cannot disarm the watchdog or change its period.

Once enabled, the block counts down a programmed number of time units. One unit is a parameterised number of slow-clock ticks (512 by default, so 64 units are about one second at 32 kHz). Software keeps the system alive by writing the restart code, which reloads the countdown. On expiry, or on a software reset request, the block emits a system reset pulse of fixed length. It can also drive an external reset pin at a chosen polarity and raise a sticky interrupt flag.

Accepted writes cross into the slow domain through a toggle handshake that carries a command and a configuration snapshot. The port holds `wr_ready` low until the crossing has completed, so no accepted write is lost.

Top module: `keyed_wdt`

## Requirements
- R1: A write to offset 0x00 updates the mode register only when data bits [31:24] equal 0x22. Mode bit 0 enables counting, bit 1 selects pin polarity (1 = active high, 0 = active low), bit 2 enables the external pin, bit 3 enables the interrupt, bit 4 is auto-start and bit 6 is dual mode. Bits 4 and 6 are stored only. A read of 0x00 returns the stored bits with all other bits zero.
- R2: A write to offset 0x04 updates the timeout length only when data bits [4:0] equal 0x08. The length sits in bits [5+LEN_W-1:5], and a read of 0x04 returns it in the same position with all other bits zero.
- R3: A write with a wrong key or code, or to an unmapped offset, changes nothing: read-back values, countdown and reset output are unaffected, and unmapped reads return zero.
- R4: With counting enabled and no restart, a reset pulse begins about length × TICKS_PER_UNIT slow cycles after the countdown was loaded. The countdown then reloads and keeps running.
- R5: Writing exactly 0x00001971 to offset 0x08 reloads the countdown and clears the interrupt flag.
- R6: An accepted length write reloads the countdown with the new length at once.
- R7: Writing exactly 0x00001209 to offset 0x14 starts a reset pulse whether or not counting is enabled.
- R8: Every reset pulse on `sys_rst_o` lasts exactly RST_CYCLES slow cycles.
- R9: With the enable bit clear the countdown holds and no expiry pulse occurs. Setting the enable bit reloads the countdown.
- R10: With the pin enable set, `ext_rst_o` sits at the active level of the selected polarity during a pulse. Otherwise, and whenever the pin enable is clear, it sits at the inactive level (the inverse of the polarity bit).
- R11: On expiry with the interrupt enable set, `irq_o` rises and stays high until a restart.
- R12: A write is taken when `wr_en` and `wr_ready` are both high. `wr_ready` drops in the cycle after any accepted keyed write and returns once the slow domain has acknowledged it.
- R13: A restart and an expiry in the same slow cycle resolve in favour of the restart: no pulse and no interrupt is raised from that cycle.
- R14: After reset the mode reads 0, the length reads DEF_LEN, `sys_rst_o` and `irq_o` are low, `ext_rst_o` is high and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the register port |
| rst_n | input | 1 | Active-low reset, system domain |
| slow_clk | input | 1 | Slow watchdog clock |
| slow_rst_n | input | 1 | Active-low reset, slow domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data including key or code |
| wr_ready | output | 1 | Block can take a write this cycle |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, key fields zero |
| sys_rst_o | output | 1 | System reset pulse, active high |
| ext_rst_o | output | 1 | External reset pin, selectable polarity |
| irq_o | output | 1 | Sticky expiry interrupt flag |

## Verification
The interesting collision is a restart command landing in the slow cycle in which the countdown reaches zero. Here reload, interrupt clear and expiry all compete for the same counter and flag registers. The bench arms a short timeout and issues the restart at a series of offsets, one slow cycle apart, that straddle the expected expiry. After each restart is acknowledged it requires the interrupt flag to be low. It also requires that no further pulse appears for most of a full period. A design that let expiry win would leave the flag set, or would fire again too early.

// File: rtl/wdt_pkg.sv
// Package: shared command encoding, offsets, keys and mode bit positions
// for the keyed watchdog. Assumes byte offsets on a 32-bit word port.
package wdt_pkg;

    typedef enum logic [1:0] {
        CMD_CFG   = 2'd0,
        CMD_LEN   = 2'd1,
        CMD_KICK  = 2'd2,
        CMD_SWRST = 2'd3
    } wdt_cmd_e;

    localparam int MODE_W = 7;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_LEN   = 8'h04;
    localparam logic [7:0] OFS_KICK  = 8'h08;
    localparam logic [7:0] OFS_SWRST = 8'h14;

    localparam logic [7:0]  MODE_KEY   = 8'h22;
    localparam logic [4:0]  LEN_KEY    = 5'h08;
    localparam logic [31:0] KICK_CODE  = 32'h0000_1971;
    localparam logic [31:0] SWRST_CODE = 32'h0000_1209;

    localparam int LEN_LSB = 5;

    localparam int B_EN     = 0;
    localparam int B_POL    = 1;
    localparam int B_EXT    = 2;
    localparam int B_IRQ    = 3;
    localparam int B_AUTO   = 4;
    localparam int B_DUAL   = 6;

    localparam logic [MODE_W-1:0] MODE_MASK = 7'h5F;

endpackage

// File: rtl/wdt_sync.sv
// Module: single-bit multi-stage synchronizer.
// Assumes the input is a level (toggle) signal that changes slowly
// compared with the destination clock.
module wdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Shift the input through one flop of the chain.
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 1'b0;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 1'b0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/wdt_bus_regs.sv
// Module: system-clock register front end. It checks keys and codes, keeps
// the readable mode and length shadows, and launches one command at a time
// into the slow domain with a toggle request. The payload stays stable until
// the acknowledge toggle matches.
module wdt_bus_regs
    import wdt_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int DEF_LEN = 1984
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic              wr_ready,
    input  logic [7:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              ack_tgl,
    output logic              req_tgl,
    output wdt_cmd_e          pay_cmd,
    output logic [MODE_W-1:0] pay_mode,
    output logic [LEN_W-1:0]  pay_len,
    output logic [MODE_W-1:0] mode_q,
    output logic              cmd_send
);

    logic [LEN_W-1:0] len_q;
    logic             fire;
    logic             hit_mode, hit_len, hit_kick, hit_swrst;
    logic [MODE_W-1:0] mode_new;
    logic [LEN_W-1:0]  len_new;

    // Ready while no command is in flight.
    assign wr_ready = (req_tgl == ack_tgl);
    assign fire     = wr_en && wr_ready;

    // Decode which keyed operation, if any, this write performs.
    always_comb begin
        hit_mode  = fire && (wr_addr == OFS_MODE)  && (wr_data[31:24] == MODE_KEY);
        hit_len   = fire && (wr_addr == OFS_LEN)   && (wr_data[4:0] == LEN_KEY);
        hit_kick  = fire && (wr_addr == OFS_KICK)  && (wr_data == KICK_CODE);
        hit_swrst = fire && (wr_addr == OFS_SWRST) && (wr_data == SWRST_CODE);
        cmd_send  = hit_mode || hit_len || hit_kick || hit_swrst;
        mode_new  = hit_mode ? (wr_data[MODE_W-1:0] & MODE_MASK) : mode_q;
        len_new   = hit_len  ? wr_data[LEN_LSB +: LEN_W] : len_q;
    end

    // Update shadows and launch a command on every accepted keyed write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            len_q    <= LEN_W'(DEF_LEN);
            req_tgl  <= 1'b0;
            pay_cmd  <= CMD_CFG;
            pay_mode <= '0;
            pay_len  <= LEN_W'(DEF_LEN);
        end else if (cmd_send) begin
            mode_q   <= mode_new;
            len_q    <= len_new;
            req_tgl  <= ~req_tgl;
            pay_mode <= mode_new;
            pay_len  <= len_new;
            if (hit_mode)      pay_cmd <= CMD_CFG;
            else if (hit_len)  pay_cmd <= CMD_LEN;
            else if (hit_kick) pay_cmd <= CMD_KICK;
            else               pay_cmd <= CMD_SWRST;
        end
    end

    // Read mux: key fields are returned as zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_MODE: rd_data[MODE_W-1:0] = mode_q;
            OFS_LEN:  rd_data[LEN_LSB +: LEN_W] = len_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wdt_core.sv
// Module: slow-domain countdown, reset pulse, external pin and interrupt.
// Assumes evt is a one-cycle strobe and that the payload inputs are stable
// whenever evt is high. A restart wins over an expiry in the same cycle.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int LEN_W          = 11,
    parameter int TICKS_PER_UNIT = 512,
    parameter int RST_CYCLES     = 16,
    parameter int DEF_LEN        = 1984
) (
    input  logic              sclk,
    input  logic              srst_n,
    input  logic              evt,
    input  wdt_cmd_e          cmd,
    input  logic [MODE_W-1:0] new_mode,
    input  logic [LEN_W-1:0]  new_len,
    output logic              sys_rst_o,
    output logic              ext_rst_o,
    output logic              irq_o,
    output logic              expire_o,
    output logic [MODE_W-1:0] mode_o
);

    localparam int CNT_W = LEN_W + $clog2(TICKS_PER_UNIT) + 1;
    localparam int RST_W = $clog2(RST_CYCLES + 1);

    logic [MODE_W-1:0] mode_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [RST_W-1:0]  pulse_q;
    logic              irq_q;

    logic              en_eff, kick, swrst, reload, expire;
    logic [LEN_W-1:0]  len_eff;
    logic [CNT_W-1:0]  load_val;

    // Resolve this cycle's command against the running countdown.
    always_comb begin
        en_eff   = evt ? new_mode[B_EN] : mode_q[B_EN];
        len_eff  = evt ? new_len : len_q;
        kick     = evt && (cmd == CMD_KICK);
        swrst    = evt && (cmd == CMD_SWRST);
        reload   = kick || (evt && (cmd == CMD_LEN)) ||
                   (evt && (cmd == CMD_CFG) && new_mode[B_EN] && !mode_q[B_EN]);
        load_val = CNT_W'(len_eff) * CNT_W'(TICKS_PER_UNIT);
        expire   = en_eff && (cnt_q == '0) && !reload;
    end

    // Mirror of the configuration, refreshed on every command.
    always_ff @(posedge sclk or negedge srst_n) begin
        if (!srst_n) begin
            mode_q <= '0;
            len_q  <= LEN_W'(DEF_LEN);
        end else if (evt) begin
            mode_q <= new_mode;
            len_q  <= new_len;
        end
    end

    // Countdown: reload on command, wrap on expiry, hold when disabled.
    always_ff @(posedge sclk or negedge srst_n) begin
        if (!srst_n)              cnt_q <= CNT_W'(DEF_LEN) * CNT_W'(TICKS_PER_UNIT);
        else if (reload)          cnt_q <= load_val;
        else if (en_eff) begin
            if (cnt_q == '0)      cnt_q <= load_val;
            else                  cnt_q <= cnt_q - 1'b1;
        end
    end

    // Fixed-length reset pulse from expiry or software request.
    always_ff @(posedge sclk or negedge srst_n) begin
        if (!srst_n)              pulse_q <= '0;
        else if (expire || swrst) pulse_q <= RST_W'(RST_CYCLES);
        else if (pulse_q != '0)   pulse_q <= pulse_q - 1'b1;
    end

    // Sticky interrupt: set on expiry when enabled, cleared by restart.
    always_ff @(posedge sclk or negedge srst_n) begin
        if (!srst_n)                                    irq_q <= 1'b0;
        else if (kick)                                  irq_q <= 1'b0;
        else if (expire && (evt ? new_mode[B_IRQ] : mode_q[B_IRQ])) irq_q <= 1'b1;
    end

    assign sys_rst_o = (pulse_q != '0);
    assign ext_rst_o = (mode_q[B_EXT] && sys_rst_o) ? mode_q[B_POL] : !mode_q[B_POL];
    assign irq_o     = irq_q;
    assign expire_o  = expire;
    assign mode_o    = mode_q;

endmodule

// File: rtl/keyed_wdt.sv
// Module: top of the keyed watchdog. It joins the system-clock register
// front end to the slow-domain core through a toggle request and
// acknowledge pair. Assumes the two resets are released while the port
// is idle.
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int LEN_W          = 11,
    parameter int TICKS_PER_UNIT = 512,
    parameter int RST_CYCLES     = 16,
    parameter int DEF_LEN        = 1984,
    parameter int SYNC_STAGES    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_clk,
    input  logic        slow_rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic        wr_ready,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        sys_rst_o,
    output logic        ext_rst_o,
    output logic        irq_o
);

    logic              req_tgl, req_s, req_d, ack_b;
    wdt_cmd_e          pay_cmd;
    logic [MODE_W-1:0] pay_mode, bus_mode, core_mode;
    logic [LEN_W-1:0]  pay_len;
    logic              cmd_send, evt, core_expire;

    wdt_bus_regs #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ack_tgl(ack_b), .req_tgl(req_tgl),
        .pay_cmd(pay_cmd), .pay_mode(pay_mode), .pay_len(pay_len),
        .mode_q(bus_mode), .cmd_send(cmd_send)
    );

    wdt_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_s)
    );

    // Edge-detect register for the request toggle; also the acknowledge.
    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) req_d <= 1'b0;
        else             req_d <= req_s;
    end

    assign evt = req_s ^ req_d;

    wdt_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(req_d), .q(ack_b)
    );

    wdt_core #(
        .LEN_W(LEN_W), .TICKS_PER_UNIT(TICKS_PER_UNIT),
        .RST_CYCLES(RST_CYCLES), .DEF_LEN(DEF_LEN)
    ) u_core (
        .sclk(slow_clk), .srst_n(slow_rst_n),
        .evt(evt), .cmd(pay_cmd), .new_mode(pay_mode), .new_len(pay_len),
        .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o), .irq_o(irq_o),
        .expire_o(core_expire), .mode_o(core_mode)
    );

endmodule

// File: rtl/keyed_wdt_chk.sv
// Module: assertion checker bound into keyed_wdt. It observes both clock
// domains and the internal strobes that join the front end to the core.
module keyed_wdt_chk
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        slow_clk,
    input logic        slow_rst_n,
    input logic        wr_en,
    input logic [7:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        wr_ready,
    input logic        cmd_send,
    input logic [6:0]  bus_mode,
    input logic        evt,
    input logic [1:0]  pay_cmd,
    input logic        core_expire,
    input logic [6:0]  core_mode,
    input logic        sys_rst_o,
    input logic        ext_rst_o,
    input logic        irq_o
);

    logic [15:0] run_len;

    // Length of the current high run of the reset output.
    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n)    run_len <= '0;
        else if (sys_rst_o) run_len <= run_len + 1'b1;
        else                run_len <= '0;
    end

    // R1
    bad_mode_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && wr_addr == OFS_MODE && wr_data[31:24] != MODE_KEY)
        |=> $stable(bus_mode));

    // R12
    busy_after_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_send |=> !wr_ready);

    // R8
    pulse_len_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        run_len <= 16'(RST_CYCLES));

    // R13
    kick_beats_expiry_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (evt && pay_cmd == 2'(CMD_KICK)) |-> !core_expire);

    // R11
    kick_clears_irq_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (evt && pay_cmd == 2'(CMD_KICK)) |=> !irq_o);

    // R10
    ext_idle_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        !core_mode[B_EXT] |-> (ext_rst_o == !core_mode[B_POL]));

endmodule

bind keyed_wdt keyed_wdt_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (.*);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;

    localparam int CLK_PERIOD  = 10;
    localparam int SCLK_PERIOD = 70;
    localparam int TPU   = 4;
    localparam int RSTC  = 5;
    localparam int DLEN  = 16;
    localparam int LW    = 11;

    logic        clk = 0, rst_n = 0, slow_clk = 0, slow_rst_n = 0;
    logic        wr_en = 0;
    logic [7:0]  wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0;
    logic        wr_ready;
    logic [31:0] rd_data;
    logic        sys_rst_o, ext_rst_o, irq_o;

    int checks = 0, errors = 0;
    int pulse_cnt = 0, cur_len = 0, last_len = 0, scyc = 0;
    logic prev_rst = 0, ext_at_rise = 0;
    logic [6:0]    m_mode;
    logic [LW-1:0] m_len;

    always #(CLK_PERIOD/2)  clk = ~clk;
    always #(SCLK_PERIOD/2) slow_clk = ~slow_clk;

    keyed_wdt #(.LEN_W(LW), .TICKS_PER_UNIT(TPU), .RST_CYCLES(RSTC), .DEF_LEN(DLEN)) uut (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o), .irq_o(irq_o)
    );

    // Pulse monitor sampled away from the slow clock edge.
    always @(negedge slow_clk) begin
        scyc <= scyc + 1;
        prev_rst <= sys_rst_o;
        if (sys_rst_o && !prev_rst) begin
            pulse_cnt <= pulse_cnt + 1;
            ext_at_rise <= ext_rst_o;
            cur_len <= 1;
        end else if (sys_rst_o) cur_len <= cur_len + 1;
        else if (prev_rst) last_len <= cur_len;
    end

    function automatic logic [31:0] mode_word(input logic [6:0] m);
        return {8'h22, 17'h0, m};
    endfunction

    function automatic logic [31:0] len_word(input logic [LW-1:0] l);
        return (32'(l) << 5) | 32'h8;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic bus_issue(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_issue(a, d);
        while (!wr_ready) @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic sdelay(input int n);
        repeat (n) @(negedge slow_clk);
    endtask

    task automatic wait_pulse(input int maxc, output int d);
        int p0 = pulse_cnt;
        d = 0;
        while (pulse_cnt == p0 && d < maxc) begin
            @(negedge slow_clk); #1; d++;
        end
    endtask

    initial begin
        #(longint'(CLK_PERIOD) * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int d, p;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1; slow_rst_n = 1;
        sdelay(2);

        // R14 reset state
        bus_read(8'h00, r); chk("R14 mode", r, 0);
        bus_read(8'h04, r); chk("R14 len", r, 32'(DLEN) << 5);
        chk("R14 outs", {29'h0, sys_rst_o, irq_o, ext_rst_o}, 32'h1);
        chk("R14 ready", 32'(wr_ready), 1);

        // R1 R2 R3 random keyed and unkeyed writes, counting kept disabled
        m_mode = 0; m_len = LW'(DLEN);
        p = pulse_cnt;
        for (int i = 0; i < 60; i++) begin
            logic [31:0] dat = $urandom;
            int sel = $urandom_range(0, 4);
            logic good = $urandom_range(0, 1);
            case (sel)
                0: begin
                    dat[31:24] = good ? 8'h22 : (dat[31:24] == 8'h22 ? 8'h23 : dat[31:24]);
                    dat[0] = 0;
                    if (good) m_mode = dat[6:0] & 7'h5F;
                    bus_write(8'h00, dat);
                end
                1: begin
                    dat[4:0] = good ? 5'h08 : (dat[4:0] == 5'h08 ? 5'h09 : dat[4:0]);
                    if (good) m_len = dat[5 +: LW];
                    bus_write(8'h04, dat);
                end
                2: bus_write(8'h08, dat == 32'h1971 ? 32'h1970 : dat);
                3: bus_write(8'h14, dat == 32'h1209 ? 32'h1208 : dat);
                default: bus_write(8'h0C, dat);
            endcase
            bus_read(8'h00, r); chk("R1 mode readback", r, 32'(m_mode));
            bus_read(8'h04, r); chk("R2 len readback", r, 32'(m_len) << 5);
        end
        bus_read(8'h0C, r); chk("R3 unmapped read", r, 0);
        sdelay(4);
        chk("R3 no pulse from bad codes", pulse_cnt, p);

        // R7 R8 software reset while disabled
        bus_write(8'h00, mode_word(7'h00));
        bus_write(8'h14, 32'h1209);
        wait_pulse(10, d); chk_rng("R7 swrst pulse", d, 1, 6);
        sdelay(RSTC + 2);
        chk("R8 pulse length", last_len, RSTC);

        // R10 external pin polarity
        bus_write(8'h00, mode_word(7'h06));
        bus_write(8'h14, 32'h1209); wait_pulse(10, d); #1;
        chk("R10 active high", 32'(ext_at_rise), 1);
        sdelay(RSTC + 2);
        bus_write(8'h00, mode_word(7'h04));
        sdelay(2); chk("R10 idle high", 32'(ext_rst_o), 1);
        bus_write(8'h14, 32'h1209); wait_pulse(10, d); #1;
        chk("R10 active low", 32'(ext_at_rise), 0);
        sdelay(RSTC + 2);
        bus_write(8'h00, mode_word(7'h02));
        bus_write(8'h14, 32'h1209); wait_pulse(10, d); #1;
        chk("R10 pin disabled", 32'(ext_at_rise), 0);
        sdelay(RSTC + 2);

        // R4 expiry timing and continued counting
        bus_write(8'h00, mode_word(7'h00));
        bus_write(8'h04, len_word(8));
        bus_write(8'h00, mode_word(7'h01));
        wait_pulse(80, d); chk_rng("R4 expiry time", d, 8*TPU - 2, 8*TPU + 4);
        wait_pulse(80, d); chk_rng("R4 periodic", d, 8*TPU - 2, 8*TPU + 4);

        // R5 restarts keep it quiet
        bus_write(8'h08, 32'h1971);
        p = pulse_cnt;
        for (int i = 0; i < 5; i++) begin sdelay(20); bus_write(8'h08, 32'h1971); end
        chk("R5 kicks prevent reset", pulse_cnt, p);

        // R6 length write reloads
        sdelay(20);
        bus_write(8'h04, len_word(8));
        wait_pulse(80, d); chk_rng("R6 reload on length", d, 8*TPU - 2, 8*TPU + 4);

        // R3 wrong restart code does not reload
        bus_write(8'h08, 32'h1971);
        sdelay(20);
        bus_write(8'h08, 32'h0000_1972);
        wait_pulse(80, d); chk_rng("R3 bad kick ignored", d, 1, 8*TPU - 18);

        // R9 disable stops counting
        bus_write(8'h04, len_word(4));
        sdelay(5);
        bus_write(8'h00, mode_word(7'h00));
        p = pulse_cnt; sdelay(60);
        chk("R9 disabled no expiry", pulse_cnt, p);

        // R11 sticky interrupt, cleared by restart
        bus_write(8'h00, mode_word(7'h09));
        sdelay(4*TPU + 8);
        chk("R11 irq set", 32'(irq_o), 1);
        sdelay(10);
        chk("R11 irq sticky", 32'(irq_o), 1);
        bus_write(8'h08, 32'h1971); sdelay(1);
        chk("R11 irq cleared", 32'(irq_o), 0);
        bus_write(8'h00, mode_word(7'h00));

        // R13 restart swept across the expiry cycle
        for (int k = 10; k <= 17; k++) begin
            bus_write(8'h00, mode_word(7'h09));
            sdelay(k);
            bus_write(8'h08, 32'h1971);
            sdelay(1);
            chk("R13 irq low after kick", 32'(irq_o), 0);
            p = pulse_cnt;
            sdelay(4*TPU - 3);
            chk("R13 no pulse after kick", pulse_cnt, p);
            bus_write(8'h00, mode_word(7'h00));
            sdelay(RSTC + 2);
        end

        // R12 ready handshake, back-to-back writes
        bus_issue(8'h00, mode_word(7'h10));
        chk("R12 ready drops", 32'(wr_ready), 0);
        bus_write(8'h04, len_word(11'h123));
        bus_read(8'h00, r); chk("R12 first write kept", r, 32'h10);
        bus_read(8'h04, r); chk("R12 second write kept", r, 32'h123 << 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule